// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block fronts a scratchpad split into word-wide banks and takes one request at a time from a group of lanes. Each request carries:

- one read/write flag for the whole request;
- for every lane, an active bit, a word address and write data.

The low address bits select the bank, so consecutive words land in consecutive banks. The remaining bits select the row inside that bank. The block splits the active lanes into passes, one pass per clock. In each pass, every bank is touched at most once. Conflicts are judged only among the lanes of the request being served.

For each bank with pending lanes, a pass serves the lowest-numbered pending lane. On a read, the pass also serves every other pending lane that asks for that same word, so the value is broadcast. On a write, lanes that share a bank are always taken one per pass, even when they target the same word. As a result, the highest-numbered active lane's data is the one left in storage.

Read results are collected per lane. They are presented with the number of passes when the request finishes, and they stay valid until the next request is accepted.

The controller has three states:

- `S_IDLE` accepts a request. It moves to `S_PASS` when any lane is active, or straight to `S_DONE` when no lane is active.
- `S_PASS` runs one pass per cycle. It stays there while lanes remain pending and moves to `S_DONE` once the pass just run clears the last pending lane.
- `S_DONE` asserts the completion pulse and always returns to `S_IDLE`.

Top module: `bank_pass_sched`

## Requirements
- R1: After reset, `busy` and `done` are low and `pass_count` is zero.
- R2: A lane's bank is its word address modulo the bank count (16), and its row is the address divided by 16. A request whose active lanes fall in pairwise distinct banks (stride 1, or any one-to-one bank permutation) completes in one pass. Written data is returned by later reads of the same address.
- R3: `pass_count` equals the largest number of passes any bank needs. This is the number of distinct read addresses in that bank, or the number of active writing lanes in that bank. Stride 2 needs 2 passes and stride 8 needs 8.
- R4: Any odd address stride across the 16 lanes needs exactly one pass.
- R5: Active lanes reading one identical address are served together in a single pass, and each of them receives that word.
- R6: Writes that share a bank are serialized, including writes to one identical address. After the request, that address holds the data of the highest-numbered active lane that wrote it.
- R7: Inactive lanes neither count toward passes nor write storage. Their `rdata` slice reads as zero. A request with no active lane finishes with `pass_count` 0.
- R8: `busy` rises in the cycle after a request is accepted and stays high through `done`. A `req_valid` seen while `busy` is high is ignored.
- R9: `done` is a one-cycle pulse. It is asserted P+1 cycles after the accepting edge for a request of P passes. `pass_count` and `rdata` hold their values after `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted only while `busy` is low |
| req_write | input | 1 | 1 = every active lane writes, 0 = every active lane reads |
| req_active | input | LANES | Per-lane active bits |
| req_addr | input | LANES*AW | Per-lane word addresses, lane i at bits [i*AW +: AW] |
| req_wdata | input | LANES*DW | Per-lane write data, lane i at bits [i*DW +: DW] |
| busy | output | 1 | A request is being served |
| done | output | 1 | One-cycle completion pulse |
| pass_count | output | CW | Passes used by the last request |
| rdata | output | LANES*DW | Per-lane read results, lane i at bits [i*DW +: DW] |

## Verification
The bench builds the block with its defaults: 16 lanes, 16 banks, 8-bit word addresses and 32-bit data, which gives 16 rows per bank. With these values every stride from 1 to 8 and every case where all lanes collide on one bank fit within the 256-word space. This puts the worst case of 16 serialized passes within reach, together with mixed bank patterns where broadcasts and distinct addresses share a bank.

// File: rtl/bps_pkg.sv
package bps_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PASS = 2'd1,
        S_DONE = 2'd2
    } bps_state_t;
endpackage

// File: rtl/bank_grant.sv
// Chooses, for one pass, the lanes each bank serves: the lowest pending lane,
// plus every pending lane reading the very same word.
module bank_grant #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int AW    = 8,
    localparam int BB   = $clog2(BANKS),
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES-1:0]    pending,
    input  logic [LANES*AW-1:0] addr,
    input  logic                is_write,
    output logic [LANES-1:0]    served,
    output logic [BANKS-1:0]    bank_en,
    output logic [BANKS*LW-1:0] bank_lane
);
    logic [LW-1:0] lead [BANKS];

    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_en[b] = 1'b0;
            lead[b]    = '0;
            for (int i = 0; i < LANES; i++) begin
                if (!bank_en[b] && pending[i] && addr[i*AW +: BB] == BB'(b)) begin
                    bank_en[b] = 1'b1;
                    lead[b]    = LW'(i);
                end
            end
        end
        for (int i = 0; i < LANES; i++) begin
            logic [BB-1:0] bk;
            logic [LW-1:0] ld;
            logic          same;
            bk   = addr[i*AW +: BB];
            ld   = lead[bk];
            same = addr[int'(ld)*AW +: AW] == addr[i*AW +: AW];
            served[i] = pending[i] && bank_en[bk] &&
                        (ld == LW'(i) || (!is_write && same));
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_lane
        assign bank_lane[b*LW +: LW] = lead[b];
    end
endmodule

// File: rtl/bank_store.sv
// Register-based banks, one read/write port each.
module bank_store #(
    parameter int BANKS = 16,
    parameter int ROWS  = 16,
    parameter int DW    = 32,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic [BANKS-1:0]    we,
    input  logic [BANKS*RW-1:0] row,
    input  logic [BANKS*DW-1:0] wdata,
    output logic [BANKS*DW-1:0] rdata
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DW-1:0] mem [ROWS];
        always_ff @(posedge clk) begin
            if (we[b]) mem[row[b*RW +: RW]] <= wdata[b*DW +: DW];
        end
        assign rdata[b*DW +: DW] = mem[row[b*RW +: RW]];
    end
endmodule

// File: rtl/bank_pass_sched.sv
module bank_pass_sched #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [LANES*DW-1:0] req_wdata,
    output logic                busy,
    output logic                done,
    output logic [CW-1:0]       pass_count,
    output logic [LANES*DW-1:0] rdata
);
    import bps_pkg::*;

    localparam int BB   = $clog2(BANKS);
    localparam int LW   = $clog2(LANES);
    localparam int RW   = AW - BB;
    localparam int ROWS = 2 ** RW;

    bps_state_t state, nxt;

    logic [LANES-1:0]    pend_q;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES*DW-1:0] wdata_q;
    logic                wr_q;
    logic [CW-1:0]       cnt_q;
    logic [LANES*DW-1:0] rdata_q;

    logic [LANES-1:0]    served;
    logic [BANKS-1:0]    bank_en;
    logic [BANKS*LW-1:0] bank_lane;
    logic [BANKS-1:0]    bank_we;
    logic [BANKS*RW-1:0] bank_row;
    logic [BANKS*DW-1:0] bank_wd;
    logic [BANKS*DW-1:0] bank_rd;
    logic [LANES-1:0]    pend_next;

    bank_grant #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) grant_i (
        .pending  (pend_q),
        .addr     (addr_q),
        .is_write (wr_q),
        .served   (served),
        .bank_en  (bank_en),
        .bank_lane(bank_lane)
    );

    // Route each bank's lead lane to that bank's single port.
    for (genvar b = 0; b < BANKS; b++) begin : g_port
        logic [LW-1:0] ld;
        assign ld = bank_lane[b*LW +: LW];
        assign bank_row[b*RW +: RW] = addr_q[int'(ld)*AW + BB +: RW];
        assign bank_wd[b*DW +: DW]  = wdata_q[int'(ld)*DW +: DW];
        assign bank_we[b] = bank_en[b] && wr_q && (state == S_PASS);
    end

    bank_store #(.BANKS(BANKS), .ROWS(ROWS), .DW(DW)) store_i (
        .clk  (clk),
        .we   (bank_we),
        .row  (bank_row),
        .wdata(bank_wd),
        .rdata(bank_rd)
    );

    assign pend_next = pend_q & ~served;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req_valid) nxt = (req_active != '0) ? S_PASS : S_DONE;
            S_PASS: if (pend_next == '0) nxt = S_DONE;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy       = (state != S_IDLE);
        done       = (state == S_DONE);
        pass_count = cnt_q;
        rdata      = rdata_q;
    end

    // Request capture and per-pass datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            cnt_q   <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    pend_q  <= req_active;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    wr_q    <= req_write;
                    cnt_q   <= '0;
                    rdata_q <= '0;
                end
                S_PASS: begin
                    pend_q <= pend_next;
                    cnt_q  <= cnt_q + 1'b1;
                    for (int i = 0; i < LANES; i++) begin
                        if (served[i] && !wr_q)
                            rdata_q[i*DW +: DW] <= bank_rd[int'(addr_q[i*AW +: BB])*DW +: DW];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bank_pass_sched_chk.sv
module bank_pass_sched_chk #(
    parameter int LANES = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] pass_count
);
    // R9: completion only inside a busy interval
    assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: busy never drops without a completion
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R8: busy only starts from an accepted request
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R3: never more passes than lanes
    assert_pass_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass_count <= CW'(LANES)));

    // R7: a zero-pass request completes right after acceptance
    assert_empty_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass_count == '0) |-> $past(req_valid && !busy));
endmodule

bind bank_pass_sched bank_pass_sched_chk #(.LANES(LANES), .CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .pass_count(pass_count)
);

// File: tb/bank_pass_sched_tb_top.sv
module bank_pass_sched_tb_top;
    localparam int LANES = 16;
    localparam int BANKS = 16;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int CW    = 5;
    localparam int WORDS = 256;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_write = 1'b0;
    logic [LANES-1:0]    req_active = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES*DW-1:0] req_wdata = '0;
    logic                busy, done;
    logic [CW-1:0]       pass_count;
    logic [LANES*DW-1:0] rdata;

    bank_pass_sched #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_active(req_active), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .pass_count(pass_count), .rdata(rdata)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int k;
    logic [DW-1:0]    model [WORDS];
    logic [AW-1:0]    t_addr [LANES];
    logic [DW-1:0]    t_data [LANES];
    logic [LANES-1:0] t_act;
    bit               t_wr;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(int a);
        return {8'h5A, 8'(a), 8'(~a), 8'(a * 3)};
    endfunction

    task automatic issue();
        @(negedge clk);
        req_write  = t_wr;
        req_active = t_act;
        for (int i = 0; i < LANES; i++) begin
            req_addr[i*AW +: AW]  = t_addr[i];
            req_wdata[i*DW +: DW] = t_data[i];
        end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        check(busy == 1'b1, "R8", "busy after accept", busy, 1);
    endtask

    task automatic finish(int p, string tag);
        int bad_lane;
        logic [DW-1:0] got, exp;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        check(k == p + 1, "R9", "done latency", k, p + 1);
        check(pass_count == CW'(p), tag, "pass_count", pass_count, p);
        bad_lane = -1;
        got = '0;
        exp = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [DW-1:0] e;
            e = (!t_wr && t_act[i]) ? model[t_addr[i]] : '0;
            if (bad_lane < 0 && rdata[i*DW +: DW] !== e) begin
                bad_lane = i;
                got = rdata[i*DW +: DW];
                exp = e;
            end
        end
        check(bad_lane < 0, tag, $sformatf("rdata lane %0d", bad_lane), got, exp);
        if (t_wr)
            for (int i = 0; i < LANES; i++)
                if (t_act[i]) model[t_addr[i]] = t_data[i];
        @(negedge clk);
        check(busy == 1'b0 && pass_count == CW'(p), "R9", "idle and count held", pass_count, p);
    endtask

    task automatic run_req(bit wr, int p, string tag);
        t_wr = wr;
        issue();
        finish(p, tag);
    endtask

    task automatic t_reset();
        check(busy == 1'b0 && done == 1'b0 && pass_count == '0, "R1", "reset outputs",
              {busy, done, pass_count}, 0);
    endtask

    task automatic t_stride1();
        t_act = '1;
        for (int blk = 0; blk < 16; blk++) begin
            for (int i = 0; i < LANES; i++) begin
                t_addr[i] = AW'(blk * 16 + i);
                t_data[i] = pat(blk * 16 + i);
            end
            run_req(1'b1, 1, "R2");
        end
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'(32 + i);
        run_req(1'b0, 1, "R2");
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'(((i * 7) % 16) + 16 * (i % 4) + 64);
        run_req(1'b0, 1, "R2");
    endtask

    task automatic t_strides();
        t_act = '1;
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'(2 * i);
        run_req(1'b0, 2, "R3");
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'(8 * i);
        run_req(1'b0, 8, "R3");
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'(16 * (i % 3));
        run_req(1'b0, 3, "R3");
    endtask

    task automatic t_odd();
        t_act = '1;
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'(3 * i);
        run_req(1'b0, 1, "R4");
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'(9 + 7 * i);
        run_req(1'b0, 1, "R4");
    endtask

    task automatic t_bcast();
        t_act = '1;
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'(77);
        run_req(1'b0, 1, "R5");
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'((i % 2) ? 49 : 33);
        run_req(1'b0, 2, "R5");
    endtask

    task automatic t_wsame();
        t_act = '1;
        for (int i = 0; i < LANES; i++) begin
            t_addr[i] = AW'(40);
            t_data[i] = 32'hAB00_0000 + DW'(i);
        end
        run_req(1'b1, 16, "R6");
        run_req(1'b0, 1, "R6");
        check(model[40] == 32'hAB00_000F, "R6", "highest lane stored", rdata[0 +: DW], 32'hAB00_000F);
        t_act = 16'h03FF;
        for (int i = 0; i < LANES; i++) begin
            t_addr[i] = AW'(41);
            t_data[i] = 32'hCD00_0000 + DW'(i);
        end
        run_req(1'b1, 10, "R6");
        t_act = '1;
        run_req(1'b0, 1, "R6");
        check(rdata[15*DW +: DW] == 32'hCD00_0009, "R6", "highest active lane stored",
              rdata[15*DW +: DW], 32'hCD00_0009);
    endtask

    task automatic t_inactive();
        t_act = 16'h00F0;
        for (int i = 0; i < LANES; i++) t_addr[i] = (i < 4) ? AW'(16 * i) : AW'(96 + i);
        run_req(1'b0, 1, "R7");
        t_act = '0;
        for (int i = 0; i < LANES; i++) begin
            t_addr[i] = AW'(80 + i);
            t_data[i] = 32'hDEAD_0000 + DW'(i);
        end
        run_req(1'b1, 0, "R7");
        t_act = '1;
        run_req(1'b0, 1, "R7");
    endtask

    task automatic t_busy_ignore();
        t_act = '1;
        t_wr  = 1'b0;
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'(8 * i + 1);
        issue();
        @(negedge clk);
        k++;
        req_write  = 1'b1;
        req_active = '1;
        for (int i = 0; i < LANES; i++) begin
            req_addr[i*AW +: AW]  = AW'(192 + i);
            req_wdata[i*DW +: DW] = 32'hBAD0_0000 + DW'(i);
        end
        req_valid = 1'b1;
        @(negedge clk);
        k++;
        req_valid = 1'b0;
        finish(8, "R8");
        for (int i = 0; i < LANES; i++) t_addr[i] = AW'(192 + i);
        run_req(1'b0, 1, "R8");
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < LANES; i++) begin
            t_addr[i] = '0;
            t_data[i] = '0;
        end
        t_act = '0;
        t_wr  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stride1();
        t_strides();
        t_odd();
        t_bcast();
        t_wsame();
        t_inactive();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule